// File: doc/BRIEF.md
# Ethernet PHY Link Poller and Mode Resolver

This block watches the link of two external Ethernet PHYs and keeps a switch MAC's per-port link settings in step with them. It issues register reads through a simple management-bus master handshake: it supplies a PHY address and a register number, raises a one-cycle start, waits for busy to fall and then takes the 16-bit read data. The serial management framing sits outside the block.

When the global switch enable is high, a polling round visits port 0 and then port 1. Once a round ends, the next one starts a programmable number of clock cycles later. For each port the block reads the status register and acts only when the link bit has changed. On a loss of link it drops the port's force-link output and reads status again, because the PHY latches a link failure. On link-up it reads the control and advertisement registers. If negotiation was both enabled and completed, it also reads the partner, gigabit-control and gigabit-status registers and picks the best mode both ends share. Otherwise it takes the mode from the control register. It then drives speed, duplex and flow-control enable, and sets force-link.

Top module: `phy_link_poller`

## Requirements
- R1: A round begins only when the interval timer expires while `sw_enable` is high, and it visits port 0 before port 1. The timer counts `poll_interval` idle cycles, and a value of 0 selects the parameter `DEF_TICKS`, which defaults to half a second at 100 MHz. No management transaction starts while `sw_enable` stays low.
- R2: A status read (register 1) returning 16'h0000 or 16'hFFFF means no PHY is present. The port is left for that round, and both its outputs and its stored link state stay unchanged.
- R3: The link bit is bit 2 of register 1. A port's outputs are touched only when that bit differs from the stored previous value. After reset the stored value is "unknown", so the first poll of a present PHY always acts: with the link down it performs two status reads.
- R4: When the first status read shows the link down where it was not known to be down, the port's force-link output is cleared before register 1 is read a second time. The link bit of the second read becomes the new link state, and if it shows the link up the port is resolved as on link-up.
- R5: Negotiation counts as used only when register 0 bit 12 and register 1 bit 5 are both set. Registers 5, 9 and 10 are read only in that case.
- R6: With negotiation used, pause is enabled when register 4 bit 10 and register 5 bit 10 are both set.
- R7: With negotiation used, the mode is the first available of: 1G full (reg 9 bit 9 and reg 10 bit 11), 1G half (reg 9 bit 8 and reg 10 bit 10), 100M full (reg 4 and reg 5 bit 8), 100M half (bit 7), 10M full (bit 6), 10M half (bit 5, or when no mode is common).
- R8: Without negotiation, pause is register 4 bit 10. Speed is 1G when register 0 bit 6 is set, otherwise 100M when register 0 bit 13 is set, otherwise 10M. Duplex is register 0 bit 8.
- R9: `link_speed` uses the encoding 0 = 10M, 1 = 100M, 2 = 1G, and `link_duplex` 1 = full. After a link-up resolution, speed, duplex and pause are updated and `link_force` is set.
- R10: Only one transaction is outstanding. `mdio_start` is a one-cycle pulse, and `mdio_phy` and `mdio_reg` hold steady until `mdio_busy` is seen low, which is the cycle the read data is taken.
- R11: A port whose `port_skip` bit is high gets no transaction at its PHY address, and its outputs stay unchanged.
- R12: After reset all link outputs and `mdio_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_enable | input | 1 | Global switch enable; rounds start only while high |
| poll_interval | input | CNT_W | Idle cycles between rounds; 0 selects DEF_TICKS |
| port_phy_addr | input | NPORT x ADDR_W | Management address of each port's PHY |
| port_skip | input | NPORT | Per-port disable of polling |
| mdio_start | output | 1 | One-cycle request to read a PHY register |
| mdio_phy | output | ADDR_W | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_busy | input | 1 | Transaction in progress |
| mdio_rdata | input | 16 | Read data, valid when busy is low after a request |
| link_speed | output | NPORT x 2 | Per-port speed code |
| link_duplex | output | NPORT | Per-port duplex (1 = full) |
| link_pause | output | NPORT | Per-port flow-control enable |
| link_force | output | NPORT | Per-port force-link |

## Verification
A port's outputs settle within one round: the transaction that returns its last register is followed by one evaluation cycle and one apply cycle, and the output registers change on the edge after that. A round can begin up to `poll_interval` cycles after enable. The bench therefore changes the PHY model only while `sw_enable` is low and the block is idle, then enables polling for a window long enough to hold at least two rounds. It then lets the last round drain and samples every output at the falling edge. Counts of requests per register and per PHY address are sampled at the same edge, so that the reads are known exactly: the double status read on the first poll, the absence of partner and gigabit reads without negotiation, and no reads to a skipped port.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;

  localparam int REG_W = 5;
  localparam int DATA_W = 16;

  localparam logic [1:0] SPD_10   = 2'd0;
  localparam logic [1:0] SPD_100  = 2'd1;
  localparam logic [1:0] SPD_1000 = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_PORT, S_REQ, S_WAIT, S_EVAL, S_APPLY, S_NEXT
  } poll_state_t;

  typedef enum logic [2:0] {
    RD_ST1, RD_ST2, RD_CTL, RD_ADV, RD_LPA, RD_GCT, RD_GST
  } rd_step_t;

  // Captured register fields needed for resolution
  typedef struct packed {
    logic       aneg_en;    // reg0[12]
    logic       sel_1g;     // reg0[6]
    logic       sel_100;    // reg0[13]
    logic       dup;        // reg0[8]
    logic       loc_pause;  // reg4[10]
    logic [3:0] loc_abil;   // reg4[8:5]
    logic       lp_pause;   // reg5[10]
    logic [3:0] lp_abil;    // reg5[8:5]
    logic [1:0] g_loc;      // reg9[9:8]
    logic [1:0] g_lp;       // reg10[11:10]
  } phy_caps_t;

  function automatic logic [REG_W-1:0] step_reg(rd_step_t s);
    case (s)
      RD_ST1, RD_ST2: return 5'd1;
      RD_CTL:         return 5'd0;
      RD_ADV:         return 5'd4;
      RD_LPA:         return 5'd5;
      RD_GCT:         return 5'd9;
      default:        return 5'd10;
    endcase
  endfunction

endpackage

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
  parameter int CNT_W     = 32,
  parameter int DEF_TICKS = 50_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] interval,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (interval == '0) ? CNT_W'(DEF_TICKS) : interval;
  assign fire  = run && (cnt >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || fire) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R1: the counter never passes the limit while waiting
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit - 1'b1) || (limit == '0) || $changed(interval));
endmodule

// File: rtl/phy_mode_resolver.sv
module phy_mode_resolver
  import phy_poll_pkg::*;
(
  input  logic      aneg_used,
  input  phy_caps_t caps,
  output logic [1:0] spd,
  output logic       dup,
  output logic       pause
);
  logic [5:0] common;

  // {1G-F, 1G-H, 100-F, 100-H, 10-F, 10-H}
  assign common = {caps.g_loc & caps.g_lp, caps.loc_abil & caps.lp_abil};

  always_comb begin
    if (aneg_used) begin
      pause = caps.loc_pause & caps.lp_pause;
      if (common[5])      begin spd = SPD_1000; dup = 1'b1; end
      else if (common[4]) begin spd = SPD_1000; dup = 1'b0; end
      else if (common[3]) begin spd = SPD_100;  dup = 1'b1; end
      else if (common[2]) begin spd = SPD_100;  dup = 1'b0; end
      else if (common[1]) begin spd = SPD_10;   dup = 1'b1; end
      else                begin spd = SPD_10;   dup = 1'b0; end
    end else begin
      pause = caps.loc_pause;
      spd   = caps.sel_1g ? SPD_1000 : (caps.sel_100 ? SPD_100 : SPD_10);
      dup   = caps.dup;
    end
  end
endmodule

// File: rtl/phy_port_out.sv
module phy_port_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       apply,
  input  logic [1:0] spd_i,
  input  logic       dup_i,
  input  logic       pause_i,
  output logic [1:0] spd_o,
  output logic       dup_o,
  output logic       pause_o,
  output logic       force_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      spd_o <= '0; dup_o <= 1'b0; pause_o <= 1'b0; force_o <= 1'b0;
    end else if (clr) begin
      force_o <= 1'b0;
    end else if (apply) begin
      spd_o <= spd_i; dup_o <= dup_i; pause_o <= pause_i; force_o <= 1'b1;
    end
  end

  // R9: force rises only through an apply; speed code never 3
  a_r9_force_from_apply: assert property (@(posedge clk) disable iff (rst)
    $rose(force_o) |-> $past(apply));
  a_r9_speed_legal: assert property (@(posedge clk) disable iff (rst)
    spd_o != 2'd3);
  // R4: a clear drops force on the next edge
  a_r4_clear_drops_force: assert property (@(posedge clk) disable iff (rst)
    clr |=> !force_o);
endmodule

// File: rtl/phy_link_poller.sv
module phy_link_poller
  import phy_poll_pkg::*;
#(
  parameter int NPORT     = 2,
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 32,
  parameter int DEF_TICKS = 50_000_000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sw_enable,
  input  logic [CNT_W-1:0]             poll_interval,
  input  logic [NPORT-1:0][ADDR_W-1:0] port_phy_addr,
  input  logic [NPORT-1:0]             port_skip,
  output logic                         mdio_start,
  output logic [ADDR_W-1:0]            mdio_phy,
  output logic [REG_W-1:0]             mdio_reg,
  input  logic                         mdio_busy,
  input  logic [DATA_W-1:0]            mdio_rdata,
  output logic [NPORT-1:0][1:0]        link_speed,
  output logic [NPORT-1:0]             link_duplex,
  output logic [NPORT-1:0]             link_pause,
  output logic [NPORT-1:0]             link_force
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  poll_state_t     state;
  rd_step_t        step;
  logic [PW-1:0]   port;
  logic [NPORT-1:0] prev_known, prev_link;
  logic            st_ok, st_link, st_cmp;
  phy_caps_t       caps;
  logic            fire, aneg_used, changed;
  logic [1:0]      r_spd;
  logic            r_dup, r_pause;

  // evaluation decisions
  logic            ev_issue, ev_down;
  rd_step_t        ev_step;
  poll_state_t     ev_state;

  assign mdio_start = (state == S_REQ);
  assign aneg_used  = caps.aneg_en & st_cmp;
  assign changed    = !prev_known[port] || (prev_link[port] != st_link);

  phy_poll_timer #(.CNT_W(CNT_W), .DEF_TICKS(DEF_TICKS)) u_timer (
    .clk(clk), .rst(rst), .run(state == S_IDLE),
    .interval(poll_interval), .fire(fire));

  phy_mode_resolver u_resolve (
    .aneg_used(aneg_used), .caps(caps),
    .spd(r_spd), .dup(r_dup), .pause(r_pause));

  always_comb begin
    ev_issue = 1'b0; ev_down = 1'b0; ev_step = step; ev_state = S_NEXT;
    case (step)
      RD_ST1: if (st_ok && changed) begin
        ev_issue = 1'b1;
        ev_step  = st_link ? RD_CTL : RD_ST2;
      end
      RD_ST2: if (st_link) begin ev_issue = 1'b1; ev_step = RD_CTL; end
              else ev_down = 1'b1;
      RD_CTL: begin ev_issue = 1'b1; ev_step = RD_ADV; end
      RD_ADV: if (aneg_used) begin ev_issue = 1'b1; ev_step = RD_LPA; end
              else ev_state = S_APPLY;
      RD_LPA: begin ev_issue = 1'b1; ev_step = RD_GCT; end
      RD_GCT: begin ev_issue = 1'b1; ev_step = RD_GST; end
      default: ev_state = S_APPLY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; step <= RD_ST1; port <= '0;
      prev_known <= '0; prev_link <= '0;
      mdio_phy <= '0; mdio_reg <= '0;
      st_ok <= 1'b0; st_link <= 1'b0; st_cmp <= 1'b0; caps <= '0;
    end else begin
      case (state)
        S_IDLE: if (fire && sw_enable) begin port <= '0; state <= S_PORT; end
        S_PORT: if (port_skip[port]) state <= S_NEXT;
                else begin
                  step <= RD_ST1; mdio_phy <= port_phy_addr[port];
                  mdio_reg <= step_reg(RD_ST1); state <= S_REQ;
                end
        S_REQ:  state <= S_WAIT;
        S_WAIT: if (!mdio_busy) begin
          case (step)
            RD_ST1, RD_ST2: begin
              st_ok   <= (mdio_rdata != '0) && (mdio_rdata != '1);
              st_link <= mdio_rdata[2];
              st_cmp  <= mdio_rdata[5];
            end
            RD_CTL: begin
              caps.aneg_en <= mdio_rdata[12]; caps.sel_1g <= mdio_rdata[6];
              caps.sel_100 <= mdio_rdata[13]; caps.dup    <= mdio_rdata[8];
            end
            RD_ADV: begin caps.loc_pause <= mdio_rdata[10]; caps.loc_abil <= mdio_rdata[8:5]; end
            RD_LPA: begin caps.lp_pause  <= mdio_rdata[10]; caps.lp_abil  <= mdio_rdata[8:5]; end
            RD_GCT: caps.g_loc <= mdio_rdata[9:8];
            default: caps.g_lp <= mdio_rdata[11:10];
          endcase
          state <= S_EVAL;
        end
        S_EVAL: if (ev_issue) begin
          step <= ev_step; mdio_phy <= port_phy_addr[port];
          mdio_reg <= step_reg(ev_step); state <= S_REQ;
        end else begin
          state <= ev_state;
          if (ev_down) begin prev_known[port] <= 1'b1; prev_link[port] <= 1'b0; end
        end
        S_APPLY: begin
          prev_known[port] <= 1'b1; prev_link[port] <= 1'b1; state <= S_NEXT;
        end
        default: if (port == PW'(NPORT - 1)) state <= S_IDLE;
                 else begin port <= port + 1'b1; state <= S_PORT; end
      endcase
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic clr_i, app_i;
    assign clr_i = (state == S_EVAL) && (step == RD_ST1) && (port == PW'(i)) &&
                   st_ok && changed && !st_link;
    assign app_i = (state == S_APPLY) && (port == PW'(i));
    phy_port_out u_out (
      .clk(clk), .rst(rst), .clr(clr_i), .apply(app_i),
      .spd_i(r_spd), .dup_i(r_dup), .pause_i(r_pause),
      .spd_o(link_speed[i]), .dup_o(link_duplex[i]),
      .pause_o(link_pause[i]), .force_o(link_force[i]));
  end

  // R10: single-cycle request, address held while waiting
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    mdio_start |=> !mdio_start);
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> ($stable(mdio_phy) && $stable(mdio_reg)));
  // R1: a round only begins with the enable high
  a_r1_round_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (state == S_PORT && $past(state) == S_IDLE) |-> $past(sw_enable));
  // R4: force is already low when the status register is re-read
  a_r4_reread_force_low: assert property (@(posedge clk) disable iff (rst)
    (mdio_start && step == RD_ST2) |-> !link_force[port]);
  // R5: partner register read only with negotiation used
  a_r5_partner_needs_aneg: assert property (@(posedge clk) disable iff (rst)
    (mdio_start && mdio_reg == 5'd5) |-> (caps.aneg_en && st_cmp));
  // R11: no request for a skipped port
  a_r11_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    mdio_start |-> !port_skip[port]);
endmodule

// File: tb/phy_link_poller_tb.sv
module phy_link_poller_tb;
  localparam logic [4:0] A0 = 5'd2, A1 = 5'd5;

  logic clk = 0, rst = 1, sw_enable = 0;
  logic [31:0] poll_interval = 0;
  logic [1:0][4:0] port_phy_addr;
  logic [1:0] port_skip = 0;
  logic mdio_start, mdio_busy = 0;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_rdata = 0;
  logic [1:0][1:0] link_speed;
  logic [1:0] link_duplex, link_pause, link_force;

  always #5 clk = ~clk;
  assign port_phy_addr[0] = A0;
  assign port_phy_addr[1] = A1;

  phy_link_poller u_dut (.*);

  // PHY model
  logic [15:0] m_ctl[2], m_st[2], m_adv[2], m_lpa[2], m_g9[2], m_g10[2];
  int latch_req[2], latch_done[2];
  int n_chk = 0, n_fail = 0;

  // monitor counters (only written here)
  int n_start = 0, p1_starts = 0, r1_p0 = 0, r10_err = 0, falls0 = 0;
  int reg_cnt[32];
  logic [4:0] first_phy = 5'h1f, hold_phy, hold_reg;
  bit seen_first = 0, prev_start = 0;
  logic prev_f0 = 0;

  initial for (int i = 0; i < 32; i++) reg_cnt[i] = 0;

  always @(negedge clk) if (!rst) begin
    if (mdio_start) begin
      n_start++; reg_cnt[mdio_reg]++;
      if (mdio_phy == A1) p1_starts++;
      if (mdio_phy == A0 && mdio_reg == 5'd1) r1_p0++;
      if (!seen_first) begin seen_first = 1; first_phy = mdio_phy; end
      if (prev_start) r10_err++;
      hold_phy = mdio_phy; hold_reg = mdio_reg;
    end else if (mdio_busy && (mdio_phy != hold_phy || mdio_reg != hold_reg)) r10_err++;
    prev_start = mdio_start;
    if (prev_f0 && !link_force[0]) falls0++;
    prev_f0 = link_force[0];
  end

  // responder: busy from the falling edge after a start for 3 cycles
  initial forever begin
    @(negedge clk);
    if (mdio_start) begin
      int p;
      logic [15:0] d;
      mdio_busy = 1;
      repeat (3) @(negedge clk);
      p = (hold_phy == A0) ? 0 : (hold_phy == A1) ? 1 : -1;
      if (p < 0) d = 16'hFFFF;
      else case (hold_reg)
        5'd0: d = m_ctl[p];
        5'd1: begin
          d = m_st[p];
          if (latch_req[p] > latch_done[p]) begin d[2] = 0; latch_done[p]++; end
        end
        5'd4: d = m_adv[p];  5'd5: d = m_lpa[p];
        5'd9: d = m_g9[p];   5'd10: d = m_g10[p];
        default: d = 16'h0000;
      endcase
      mdio_rdata = d; mdio_busy = 0;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic logic [3:0] exp_mode(logic [15:0] c, s, a, l, g9, g10);
    logic [1:0] sp; logic du, pa; logic [15:0] g, m;
    if (c[12] && s[5]) begin
      pa = a[10] & l[10]; g = (g9 << 2) & g10; m = a & l;
      if (g[11]) begin sp = 2; du = 1; end
      else if (g[10]) begin sp = 2; du = 0; end
      else if (m[8]) begin sp = 1; du = 1; end
      else if (m[7]) begin sp = 1; du = 0; end
      else if (m[6]) begin sp = 0; du = 1; end
      else begin sp = 0; du = 0; end
    end else begin
      pa = a[10]; sp = c[6] ? 2 : (c[13] ? 1 : 0); du = c[8];
    end
    return {sp, du, pa};
  endfunction

  task automatic set_phy(int p, bit lnk, bit cmp, logic [15:0] c, a, l, g9, g10);
    m_st[p] = 16'h7809 | (16'(lnk) << 2) | (16'(cmp) << 5);
    m_ctl[p] = c; m_adv[p] = a; m_lpa[p] = l; m_g9[p] = g9; m_g10[p] = g10;
  endtask

  task automatic window();
    sw_enable = 1; repeat (400) @(negedge clk);
    sw_enable = 0; repeat (200) @(negedge clk);
  endtask

  task automatic check_port(int p, string tag);
    logic [3:0] e;
    e = exp_mode(m_ctl[p], m_st[p], m_adv[p], m_lpa[p], m_g9[p], m_g10[p]);
    chk({link_speed[p], link_duplex[p], link_pause[p]} == e, tag,
        {link_speed[p], link_duplex[p], link_pause[p]}, e);
    chk(link_force[p] == 1'b1, {tag, " force"}, link_force[p], 1);
  endtask

  task automatic down_up(int p, logic [5:0] mask, bit pause, string tag);
    set_phy(p, 0, 0, 16'h1000, 0, 0, 0, 0); window();
    chk(link_force[p] == 0, "R4 force low after link loss", link_force[p], 0);
    set_phy(p, 1, 1, 16'h1000, (16'(mask[3:0]) << 5) | (16'(pause) << 10),
            (16'(mask[3:0]) << 5) | 16'h0400, 16'(mask[5:4]) << 8, 16'(mask[5:4]) << 10);
    window(); check_port(p, tag);
  endtask

  initial begin
    int s0, s1, k;
    logic [1:0][1:0] sv_spd; logic [1:0] sv_frc;
    void'($urandom(32'd4321));
    for (int p = 0; p < 2; p++) begin
      set_phy(p, 0, 0, 0, 0, 0, 0, 0); latch_req[p] = 0; latch_done[p] = 0;
    end
    sw_enable = 1;
    repeat (3) @(negedge clk); rst = 0; @(negedge clk);
    chk(link_force == 0 && link_speed == 0 && link_duplex == 0 && link_pause == 0 && !mdio_start,
        "R12 reset state", {link_force, link_pause}, 0);
    // interval 0 selects the long default: nothing in 2000 cycles
    repeat (2000) @(negedge clk);
    chk(n_start == 0, "R1 default interval not expired", n_start, 0);
    sw_enable = 0; poll_interval = 100; repeat (10) @(negedge clk);
    // first poll with link down acts: two status reads on port 0
    sw_enable = 1; k = 0;
    while (p1_starts == 0 && k < 2000) begin @(negedge clk); k++; end
    chk(first_phy == A0, "R1 port 0 first", first_phy, A0);
    chk(r1_p0 == 2, "R3 first poll re-reads status", r1_p0, 2);
    sw_enable = 0; repeat (200) @(negedge clk);
    chk(link_force == 0, "R3 force low after first poll", link_force, 0);
    // priority ladder and pause (R7, R6, R9)
    down_up(0, 6'b111111, 1, "R7 1G full");
    down_up(0, 6'b011111, 0, "R7 1G half");
    down_up(0, 6'b001111, 1, "R7 100M full");
    down_up(0, 6'b000111, 0, "R7 100M half");
    down_up(0, 6'b000011, 1, "R7 10M full");
    down_up(0, 6'b000001, 0, "R6 10M half no pause");
    down_up(0, 6'b000000, 1, "R7 none common");
    // fallback without negotiation (R8, R5)
    s0 = reg_cnt[5] + reg_cnt[9] + reg_cnt[10];
    set_phy(0, 0, 0, 0, 0, 0, 0, 0); window();
    set_phy(0, 1, 0, 16'h2100, 16'h0400, 16'h01E0, 16'h0300, 16'h0C00); window();
    check_port(0, "R8 fallback 100 full pause");
    set_phy(0, 0, 0, 0, 0, 0, 0, 0); window();
    set_phy(0, 1, 0, 16'h1040, 16'h01E0, 16'h05E0, 16'h0300, 16'h0C00); window();
    check_port(0, "R8 aneg incomplete 1G half");
    s1 = reg_cnt[5] + reg_cnt[9] + reg_cnt[10];
    chk(s1 == s0, "R5 no partner reads without aneg", s1 - s0, 0);
    // latched-low re-read (R4): up with 1G full, then change mode and latch
    down_up(0, 6'b111111, 1, "R4 setup");
    s0 = falls0;
    set_phy(0, 1, 1, 16'h1000, 16'h0080, 16'h0080, 0, 0);
    latch_req[0]++; window();
    check_port(0, "R4 re-read resolves new mode");
    chk(falls0 - s0 == 1, "R4 force dropped once", falls0 - s0, 1);
    // missing PHY (R2)
    sv_spd = link_speed;
    m_st[0] = 16'hFFFF; m_ctl[0] = 16'h0000; window();
    chk(link_speed[0] == sv_spd[0] && link_force[0], "R2 all-ones ignored", link_speed[0], sv_spd[0]);
    m_st[0] = 16'h0000; window();
    chk(link_speed[0] == sv_spd[0] && link_force[0], "R2 all-zeros ignored", link_speed[0], sv_spd[0]);
    set_phy(0, 1, 1, 16'h1000, 16'h0100, 16'h0100, 0, 0); window();
    chk(link_speed[0] == sv_spd[0], "R2 stored state kept", link_speed[0], sv_spd[0]);
    // random trials on both ports (R7, R8, R6)
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 2; p++) set_phy(p, 0, 0, 0, 0, 0, 0, 0);
      window();
      chk(link_force == 0, "R4 random link loss", link_force, 0);
      for (int p = 0; p < 2; p++)
        set_phy(p, 1, $urandom % 2, 16'($urandom) & 16'h3140, 16'($urandom) & 16'h05E0,
                16'($urandom) & 16'h05E0, 16'($urandom) & 16'h0300, 16'($urandom) & 16'h0C00);
      window();
      check_port(0, "R7 random port 0");
      check_port(1, "R8 random port 1");
    end
    // port skip (R11)
    port_skip = 2'b10; sv_frc = link_force; sv_spd = link_speed; s0 = p1_starts;
    set_phy(1, 0, 0, 0, 0, 0, 0, 0); window();
    chk(p1_starts == s0, "R11 no reads to skipped port", p1_starts - s0, 0);
    chk(link_force[1] == sv_frc[1] && link_speed[1] == sv_spd[1], "R11 outputs kept",
        link_force[1], sv_frc[1]);
    port_skip = 0;
    // disabled: no transactions (R1)
    s0 = n_start; repeat (600) @(negedge clk);
    chk(n_start == s0, "R1 quiet while disabled", n_start - s0, 0);
    chk(r10_err == 0, "R10 one outstanding request, address held", r10_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule